// File: doc/BRIEF.md
# Hit Capture Front-End Controller

This block serves one timing channel. It takes the discriminator hit, which has no timing relation to the logic clock, and passes it through a synchronizer. It then issues two capture strobes. The first strobe marks where a pulse starts and the second marks where it ends. Each strobe freezes the oscillator phase and coarse-count code that the time-digitizer presents on `code_i`. The code is `{coarse, fine}`, with the fine part in the low `FINE_W` bits.

Captures are grouped into sampling windows. Each window is built from the reference tick `tick_i`, and its length is chosen at run time: every fourth tick (base rate), every second tick (double rate) or every tick (quadruple rate). When a window closes, the block emits at most one record. The record holds the arrival code and a coarse-only pulse width, together with flags for a missing trailing edge and for pile-up. Records are suppressed while the loop clock reports loss of lock. The records go on to the decode, processing and serializer stages.

Top module: `hit_capture_fe`

## Requirements
- R1: While `rst_ni` is low, every output is zero.
- R2: Suppose `hit_i` is first sampled high at clock edge k after being sampled low at edge k-1. Then `cap_lead_o` is high for the cycle between edges k+1 and k+2, provided no arrival has yet been accepted in the current window. When that happens, `code_i` from that cycle is kept as the arrival code.
- R3: A falling edge of the hit is seen with the same two-edge latency as in R2. It drives `cap_trail_o` high for one cycle only when all of the following hold: an arrival was accepted in the window, no trailing edge has yet been accepted, and the cycle does not end the window. The coarse part of `code_i` is then kept.
- R4: A window ends in a cycle with `tick_i` high when a tick count has its low bits all ones. The count starts at 0 after reset and advances once per tick. For `rate_sel_i` = 0 the low bits are two bits (every 4th tick); for 1 they are one bit (every 2nd tick); for 2 and 3 there are none, so every tick ends a window.
- R5: `rec_valid_o` is high for exactly the cycle after a window-end cycle. It is high only if an arrival was accepted in that window and R11 allows it.
- R6: `rec_toa_o` equals the arrival code kept for that window.
- R7: If a trailing edge was kept, `rec_tot_o` equals its coarse value minus the arrival's coarse value (`code[TS_W-1:FINE_W]`), modulo 2^COARSE_W, and `rec_sat_o` is 0.
- R8: If no trailing edge was kept in the window, `rec_tot_o` is all ones and `rec_sat_o` is 1.
- R9: A rising edge after the accepted arrival, in a cycle that does not end the window, sets `rec_pile_o` in that window's record. Such an edge raises no strobe.
- R10: Edges in a window-end cycle belong to the next window. A rising edge there is accepted as the next window's arrival. A falling edge there is ignored.
- R11: If `lock_i` is low in a window-end cycle, no record is emitted for that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | 1 | Asynchronous discriminator hit |
| tick_i | input | 1 | Reference tick, one cycle wide |
| rate_sel_i | input | 2 | Window length select: 0 = 4 ticks, 1 = 2 ticks, 2/3 = 1 tick |
| lock_i | input | 1 | Loop clock locked |
| code_i | input | TS_W | Captured `{coarse, fine}` time code |
| cap_lead_o | output | 1 | Arrival capture strobe |
| cap_trail_o | output | 1 | Trailing-edge capture strobe |
| rec_valid_o | output | 1 | Record valid, one cycle |
| rec_toa_o | output | TS_W | Arrival code |
| rec_tot_o | output | COARSE_W | Coarse width |
| rec_sat_o | output | 1 | Width saturated (no trailing edge) |
| rec_pile_o | output | 1 | Extra rising edge seen in the window |

## Verification
The bench targets the following corner cases:
- **Edges landing in the window-end cycle.** A design that let a rising edge there count for the closing window would drop the next window's arrival. One that accepted a falling edge there would report a width where a saturated record belongs.
- **Pulses longer than a window.** These must yield a saturated width rather than a stale or zero width.
- **Several pulses in one window.** These must raise the pile-up flag without overwriting the kept arrival code.
- **Width wrap.** The coarse difference has to wrap correctly when the trailing code's coarse value is below the arrival's.

Two further areas are covered:
- **Rate switching.** All three window lengths are exercised, including changes in mid-run. A wrong divider mask shifts every record by whole ticks.
- **Lock loss.** Windows closing while lock is down must produce nothing on `rec_valid_o`.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  localparam int unsigned DIV_W = 2;

  typedef enum logic [1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2,
    RATE_X4B = 2'd3
  } rate_e;

  function automatic logic [DIV_W-1:0] win_mask(rate_e r);
    case (r)
      RATE_X1: win_mask = {DIV_W{1'b1}};
      RATE_X2: win_mask = {{(DIV_W-1){1'b0}}, 1'b1};
      default: win_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/hcf_edge_sync.sv
module hcf_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_first
      assign d = hit_i;
    end else begin : g_next
      assign d = chain_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/hcf_win_timer.sv
module hcf_win_timer
  import hcf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] rate_sel_i,
  output logic       win_end_o
);
  logic [DIV_W-1:0] tick_cnt_q;
  logic [DIV_W-1:0] mask;

  assign mask      = win_mask(rate_e'(rate_sel_i));
  assign win_end_o = tick_i & ((tick_cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tick_cnt_q <= '0;
    else if (tick_i) tick_cnt_q <= tick_cnt_q + 1'b1;
  end
endmodule

// File: rtl/hcf_pair_ctrl.sv
module hcf_pair_ctrl #(
  parameter int unsigned COARSE_W = 5,
  parameter int unsigned FINE_W   = 5,
  localparam int unsigned TS_W    = COARSE_W + FINE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                win_end_i,
  input  logic                lock_i,
  input  logic [TS_W-1:0]     code_i,
  output logic                cap_lead_o,
  output logic                cap_trail_o,
  output logic                rec_valid_o,
  output logic [TS_W-1:0]     rec_toa_o,
  output logic [COARSE_W-1:0] rec_tot_o,
  output logic                rec_sat_o,
  output logic                rec_pile_o
);
  logic                got_lead_q, got_trail_q, pile_q;
  logic [TS_W-1:0]     toa_q;
  logic [COARSE_W-1:0] trail_crs_q;
  logic [COARSE_W-1:0] width;
  logic                acc_lead, acc_trail;

  // edges in the closing cycle belong to the next window
  assign acc_lead  = rise_i & (~got_lead_q | win_end_i);
  assign acc_trail = fall_i & got_lead_q & ~got_trail_q & ~win_end_i;
  assign width     = trail_crs_q - toa_q[TS_W-1:FINE_W];

  assign cap_lead_o  = acc_lead;
  assign cap_trail_o = acc_trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_lead_q  <= 1'b0;
      got_trail_q <= 1'b0;
      pile_q      <= 1'b0;
      toa_q       <= '0;
      trail_crs_q <= '0;
      rec_valid_o <= 1'b0;
      rec_toa_o   <= '0;
      rec_tot_o   <= '0;
      rec_sat_o   <= 1'b0;
      rec_pile_o  <= 1'b0;
    end else if (win_end_i) begin
      rec_valid_o <= got_lead_q & lock_i;
      rec_toa_o   <= toa_q;
      rec_tot_o   <= got_trail_q ? width : '1;
      rec_sat_o   <= ~got_trail_q;
      rec_pile_o  <= pile_q;
      got_lead_q  <= acc_lead;
      got_trail_q <= 1'b0;
      pile_q      <= 1'b0;
      if (acc_lead) toa_q <= code_i;
    end else begin
      rec_valid_o <= 1'b0;
      if (acc_lead) begin
        got_lead_q <= 1'b1;
        toa_q      <= code_i;
      end
      if (acc_trail) begin
        got_trail_q <= 1'b1;
        trail_crs_q <= code_i[TS_W-1:FINE_W];
      end
      if (rise_i & got_lead_q) pile_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hit_capture_fe.sv
module hit_capture_fe #(
  parameter int unsigned COARSE_W    = 5,
  parameter int unsigned FINE_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TS_W       = COARSE_W + FINE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_i,
  input  logic                tick_i,
  input  logic [1:0]          rate_sel_i,
  input  logic                lock_i,
  input  logic [TS_W-1:0]     code_i,
  output logic                cap_lead_o,
  output logic                cap_trail_o,
  output logic                rec_valid_o,
  output logic [TS_W-1:0]     rec_toa_o,
  output logic [COARSE_W-1:0] rec_tot_o,
  output logic                rec_sat_o,
  output logic                rec_pile_o
);
  logic rise, fall, win_end;

  hcf_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  hcf_win_timer i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rate_sel_i(rate_sel_i),
    .win_end_o (win_end)
  );

  hcf_pair_ctrl #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) i_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .fall_i     (fall),
    .win_end_i  (win_end),
    .lock_i     (lock_i),
    .code_i     (code_i),
    .cap_lead_o (cap_lead_o),
    .cap_trail_o(cap_trail_o),
    .rec_valid_o(rec_valid_o),
    .rec_toa_o  (rec_toa_o),
    .rec_tot_o  (rec_tot_o),
    .rec_sat_o  (rec_sat_o),
    .rec_pile_o (rec_pile_o)
  );
endmodule

// File: rtl/hit_capture_fe_chk.sv
module hit_capture_fe_chk #(
  parameter int unsigned COARSE_W = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                lock_i,
  input logic                win_end,
  input logic                cap_lead_o,
  input logic                cap_trail_o,
  input logic                rec_valid_o,
  input logic [COARSE_W-1:0] rec_tot_o,
  input logic                rec_sat_o
);
  logic lead_seen_q, trail_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_seen_q  <= 1'b0;
      trail_seen_q <= 1'b0;
    end else if (win_end) begin
      lead_seen_q  <= cap_lead_o;
      trail_seen_q <= 1'b0;
    end else begin
      lead_seen_q  <= lead_seen_q | cap_lead_o;
      trail_seen_q <= trail_seen_q | cap_trail_o;
    end
  end

  a_r2_one_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_lead_o |-> (!lead_seen_q || win_end));
  a_r2_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_lead_o && cap_trail_o));
  a_r3_trail_after_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_trail_o |-> (lead_seen_q && !trail_seen_q && !win_end));
  a_r5_valid_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> $past(win_end));
  a_r11_valid_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> $past(lock_i));
  a_r8_sat_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_sat_o) |-> (&rec_tot_o));
endmodule

bind hit_capture_fe hit_capture_fe_chk #(.COARSE_W(COARSE_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lock_i     (lock_i),
  .win_end    (win_end),
  .cap_lead_o (cap_lead_o),
  .cap_trail_o(cap_trail_o),
  .rec_valid_o(rec_valid_o),
  .rec_tot_o  (rec_tot_o),
  .rec_sat_o  (rec_sat_o)
);

// File: tb/test_hit_capture_fe.sv
module test_hit_capture_fe;
  localparam int CW = 5;
  localparam int FW = 5;
  localparam int TW = CW + FW;
  localparam logic [CW-1:0] CMASK = '1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          hit_i = 1'b0;
  logic          tick_i = 1'b0;
  logic [1:0]    rate_sel_i = 2'd0;
  logic          lock_i = 1'b1;
  logic [TW-1:0] code_i = '0;
  logic          cap_lead_o, cap_trail_o, rec_valid_o, rec_sat_o, rec_pile_o;
  logic [TW-1:0] rec_toa_o;
  logic [CW-1:0] rec_tot_o;

  hit_capture_fe #(.COARSE_W(CW), .FINE_W(FW)) i_hit_capture_fe (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0, tick_per = 2;
  bit done = 0;
  int cnt_ok = 0, cnt_sat = 0, cnt_pile = 0, cnt_supp = 0, cnt_r10 = 0, cnt_wrap = 0;
  int win_by_rate [4] = '{0, 0, 0, 0};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // reference-tick and code source, driven just after each edge
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    tick_i <= #1 ((cyc % tick_per) == 0);
    code_i <= #1 TW'($urandom);
  end

  // behavioural reference model
  bit hq[$] = '{0, 0, 0};
  int nt = 0;
  bit m_lead = 0, m_trail = 0, m_pile = 0;
  logic [TW-1:0] m_toa = '0;
  logic [CW-1:0] m_tc = '0;
  bit e_valid = 0, e_sat = 0, e_pile = 0;
  logic [TW-1:0] e_toa = '0;
  logic [CW-1:0] e_tot = '0;
  bit r1_done = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      hq = '{0, 0, 0}; nt = 0; m_lead = 0; m_trail = 0; m_pile = 0; e_valid = 0;
      if (!r1_done) begin
        r1_done = 1;
        chk("R1 strobes", {cap_lead_o, cap_trail_o}, 0);
        chk("R1 record", {rec_valid_o, rec_sat_o, rec_pile_o}, 0);
        chk("R1 fields", {rec_toa_o, rec_tot_o}, 0);
      end
    end else if (!done) begin
      bit rise, fall, wend, x_lead, x_trail;
      int div;
      rise = hq[1] && !hq[2];
      fall = !hq[1] && hq[2];
      div = (rate_sel_i == 2'd0) ? 4 : (rate_sel_i == 2'd1) ? 2 : 1;
      wend = tick_i && ((nt % div) == div - 1);
      x_lead = rise && (!m_lead || wend);
      x_trail = fall && m_lead && !m_trail && !wend;
      if (wend && rise && m_lead) begin
        cnt_r10++;
        chk("R10 lead at window end", cap_lead_o, 1);
      end else chk("R2 lead strobe", cap_lead_o, x_lead);
      chk("R3 trail strobe", cap_trail_o, x_trail);
      chk("R5 record valid", rec_valid_o, e_valid);
      if (e_valid) begin
        chk("R6 arrival code", rec_toa_o, e_toa);
        chk(e_sat ? "R8 saturated width" : "R7 width", rec_tot_o, e_tot);
        chk("R8 sat flag", rec_sat_o, e_sat);
        chk("R9 pile flag", rec_pile_o, e_pile);
      end
      if (wend) begin
        win_by_rate[rate_sel_i]++;
        e_valid = m_lead && lock_i;
        if (m_lead && !lock_i) cnt_supp++;
        e_toa = m_toa;
        e_sat = !m_trail;
        e_tot = m_trail ? CW'(m_tc - m_toa[TW-1:FW]) : CMASK;
        e_pile = m_pile;
        if (e_valid && m_trail) cnt_ok++;
        if (e_valid && m_trail && m_tc < m_toa[TW-1:FW]) cnt_wrap++;
        if (e_valid && !m_trail) cnt_sat++;
        if (e_valid && m_pile) cnt_pile++;
        m_lead = x_lead;
        if (x_lead) m_toa = code_i;
        m_trail = 0;
        m_pile = 0;
      end else begin
        e_valid = 0;
        if (rise && m_lead) m_pile = 1;
        if (x_lead) begin m_lead = 1; m_toa = code_i; end
        if (x_trail) begin m_trail = 1; m_tc = code_i[TW-1:FW]; end
      end
      if (tick_i) nt++;
      hq.push_front(hit_i);
      void'(hq.pop_back());
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic pulse(int len, int gap);
    hit_i = 1'b1;
    step(len);
    hit_i = 1'b0;
    step(gap);
  endtask

  task automatic rand_pulses(int n);
    for (int i = 0; i < n; i++) pulse(1 + $urandom % 12, 1 + $urandom % 12);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    step(4);
    rst_ni = 1'b1;
    step(5);
    for (int r = 0; r < 4; r++) begin
      rate_sel_i = 2'(r);
      rand_pulses(40);
      pulse(40, 6);          // longer than a window: saturate
      pulse(2, 1); pulse(2, 1); pulse(2, 10); // pile-up
      lock_i = 1'b0;         // lock loss: records suppressed
      rand_pulses(6);
      lock_i = 1'b1;
      rand_pulses(10);
    end
    tick_per = 1;            // tick every cycle, switch rate mid-run
    for (int i = 0; i < 60; i++) begin
      rate_sel_i = 2'($urandom % 3);
      pulse(1 + $urandom % 8, 1 + $urandom % 5);
    end
    step(20);
    chk("R4 windows at rate 0", win_by_rate[0] > 0, 1);
    chk("R4 windows at rate 1", win_by_rate[1] > 0, 1);
    chk("R4 windows at rate 2", win_by_rate[2] > 0, 1);
    chk("R7 paired records seen", cnt_ok > 0, 1);
    chk("R7 wrapped widths seen", cnt_wrap > 0, 1);
    chk("R8 saturated records seen", cnt_sat > 0, 1);
    chk("R9 pile-up records seen", cnt_pile > 0, 1);
    chk("R10 window-end arrivals seen", cnt_r10 > 0, 1);
    chk("R11 suppressed windows seen", cnt_supp > 0, 1);
    finish_run();
  end
endmodule